// File: doc/BRIEF.md
# Small-Memory Self-Test Sequencer

This block is a hardware self-test engine for a set of small on-chip memories. It covers a 4096-word control store built from three slices and a bank of sixteen 16-bit per-task registers. The slices are two 16-bit slices and one 4-bit slice. A start pulse begins a run. The engine first loads every task register with its own index. It then performs a fixed number of iterations.

In each iteration the engine takes a 16-bit selection word and a 16-bit pattern from its inputs. The selection word is normally supplied by an external pseudo-random source. The engine decodes the word into a target and an address, and checks the address against the legal window. It writes the pattern, reads it back one cycle later, and compares the two. For the task-register bank there is one extra step before the write: the engine confirms that the register still holds its own index. After the compare it puts that index back.

Errors are latched and reported on sticky flags. The failing target, address, expected value and actual value are held on output ports. A loop mode exists for fault hunting. In loop mode the engine does not halt on errors, and it reuses the first word and pattern it drew.

Top module: `bist_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `pass` are low, all three error flags are low, and all four counters are zero.
- R2: A start pulse writes task register i with the value i, for every i from 0 to 15, before the first iteration.
- R3: Selection word bits [15:13] pick the target: 0 is slice 0, 1 is slice 1, 2 is slice 2 and 3 is the task bank. Bits [12:1] give the store address. Bits [12:9] give the task index. At most one slice write enable is high in any cycle.
- R4: A store address below 256 or above 3583 sets `err_addr`. It causes no write, and it ends the iteration.
- R5: Target codes 4 to 7 set `err_addr`, and `fail_target` shows the code.
- R6: Task indices 14 and 15 set `err_addr` and cause no access. `fail_addr` holds the index.
- R7: For slice 2, pattern bits [15:12] are written on `cs_wdata[3:0]`. Only those 4 bits are compared. The expected and actual values are reported zero-extended.
- R8: For a task target, the register is read first. If its value differs from its index, `err_index` is set. The pattern is then still written and read back, and finally the index is written back.
- R9: A read-back value that differs from the written pattern sets `err_pattern`. The target, address, expected value and actual value are captured on the fail ports.
- R10: Without loop mode, any error ends the run after the current iteration, with `done` high and `pass` low. `pass` is high only when the run completes ITERS iterations with no error.
- R11: With loop mode set, errors do not halt the run; all ITERS iterations are performed.
- R12: With loop mode set, the selection word and pattern drawn in the first iteration are reused, and later input values are ignored.
- R13: The per-target counters each increase by one for every completed iteration on a legal address of their target.
- R14: Error flags stay set until the next start pulse, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; clears flags and counters |
| loop_mode | input | 1 | Keep running on errors and reuse the first word and pattern |
| sel_word | input | 16 | Selection word for the target and address |
| pattern | input | 16 | Data pattern to write |
| cs_addr | output | 12 | Control-store word address |
| cs_we | output | 3 | Per-slice write enables |
| cs_wdata | output | 16 | Control-store write data |
| cs_rdata0 | input | 16 | Slice 0 read data, one cycle after the address |
| cs_rdata1 | input | 16 | Slice 1 read data |
| cs_rdata2 | input | 4 | Slice 2 read data |
| tr_addr | output | 4 | Task register index |
| tr_we | output | 1 | Task register write enable |
| tr_wdata | output | 16 | Task register write data |
| tr_rdata | input | 16 | Task register read data, one cycle after the address |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with no error |
| err_pattern | output | 1 | Sticky read-back mismatch flag |
| err_index | output | 1 | Sticky task self-index mismatch flag |
| err_addr | output | 1 | Sticky illegal target or address flag |
| fail_target | output | 3 | Target code of the last failure |
| fail_addr | output | 12 | Address or task index of the last failure |
| fail_exp | output | 16 | Expected value of the last failure |
| fail_act | output | 16 | Actual value of the last failure |
| cnt_s0 | output | 16 | Slice 0 iteration count |
| cnt_s1 | output | 16 | Slice 1 iteration count |
| cnt_s2 | output | 16 | Slice 2 iteration count |
| cnt_tr | output | 16 | Task bank iteration count |

## Verification
The checker enforces some properties on every cycle:
- No slice write ever lands outside the legal address window.
- At most one slice is written at a time.
- The engine is silent on the memory ports once finished.
- `pass` never coexists with an error flag.
- Error flags only clear on a start.
- Counters only step by one.

Some behaviour can only be shown by the bench's scenarios, because it depends on memory contents and on the sequence of inputs:
- The decode of each target code and address.
- The 4-bit slice truncation.
- The self-index read and restore of task registers.
- Halting versus continuing in loop mode.
- Reuse of the first drawn word and pattern.

These scenarios use injected read faults and a corrupted initial load.

// File: rtl/bist_pkg.sv
package bist_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INIT,
    ST_FETCH,
    ST_DECODE,
    ST_IRD,
    ST_IWT,
    ST_ICMP,
    ST_WR,
    ST_RD,
    ST_WT,
    ST_CMP,
    ST_REST,
    ST_NEXT,
    ST_DONE
  } bist_state_t;

  localparam logic [2:0] TGT_S0 = 3'd0;
  localparam logic [2:0] TGT_S1 = 3'd1;
  localparam logic [2:0] TGT_S2 = 3'd2;
  localparam logic [2:0] TGT_TR = 3'd3;

endpackage

// File: rtl/bist_decode.sv
module bist_decode #(
  parameter int AW         = 12,
  parameter int TW         = 4,
  parameter int LO_ADDR    = 256,
  parameter int HI_ADDR    = 3583,
  parameter int TASK_LIMIT = 14
) (
  input  logic [AW+2:0] word,
  output logic [2:0]    code,
  output logic [AW-1:0] addr,
  output logic [TW-1:0] tidx,
  output logic          legal
);
  import bist_pkg::*;

  assign code = word[AW+2 -: 3];
  assign addr = word[AW-1:0];
  assign tidx = word[AW-1 -: TW];

  always_comb begin
    case (code)
      TGT_S0, TGT_S1, TGT_S2:
        legal = (addr >= AW'(LO_ADDR)) && (addr <= AW'(HI_ADDR));
      TGT_TR:
        legal = (int'(tidx) < TASK_LIMIT);
      default:
        legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/bist_counters.sv
module bist_counters #(
  parameter int NCNT  = 4,
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic [NCNT-1:0]            inc,
  output logic [NCNT-1:0][CNT_W-1:0] cnt
);

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst || clr)
        cnt[g] <= '0;
      else if (inc[g])
        cnt[g] <= cnt[g] + 1'b1;
    end
  end

endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl #(
  parameter int DW         = 16,
  parameter int AW         = 12,
  parameter int TW         = 4,
  parameter int CS2W       = 4,
  parameter int LO_ADDR    = 256,
  parameter int HI_ADDR    = 3583,
  parameter int TASK_LIMIT = 14,
  parameter int ITERS      = 1000,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             loop_mode,
  input  logic [DW-1:0]    sel_word,
  input  logic [DW-1:0]    pattern,
  output logic [AW-1:0]    cs_addr,
  output logic [2:0]       cs_we,
  output logic [DW-1:0]    cs_wdata,
  input  logic [DW-1:0]    cs_rdata0,
  input  logic [DW-1:0]    cs_rdata1,
  input  logic [CS2W-1:0]  cs_rdata2,
  output logic [TW-1:0]    tr_addr,
  output logic             tr_we,
  output logic [DW-1:0]    tr_wdata,
  input  logic [DW-1:0]    tr_rdata,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic             err_pattern,
  output logic             err_index,
  output logic             err_addr,
  output logic [2:0]       fail_target,
  output logic [AW-1:0]    fail_addr,
  output logic [DW-1:0]    fail_exp,
  output logic [DW-1:0]    fail_act,
  output logic [CNT_W-1:0] cnt_s0,
  output logic [CNT_W-1:0] cnt_s1,
  output logic [CNT_W-1:0] cnt_s2,
  output logic [CNT_W-1:0] cnt_tr
);
  import bist_pkg::*;

  localparam int NTASK = 1 << TW;
  localparam int ITW   = $clog2(ITERS + 1);
  localparam int SELW  = AW + 3;

  bist_state_t     state;
  logic [TW-1:0]   init_idx;
  logic [DW-1:0]   cur_word;
  logic [DW-1:0]   cur_pat;
  logic            have_word;
  logic [ITW-1:0]  iter;
  logic [DW-1:0]   rd_q;

  logic [2:0]      code;
  logic [AW-1:0]   addr;
  logic [TW-1:0]   tidx;
  logic            legal;
  logic [DW-1:0]   exp_val;
  logic [3:0]      inc;
  logic [3:0][CNT_W-1:0] cnt;
  logic            any_err;

  bist_decode #(
    .AW(AW), .TW(TW), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .TASK_LIMIT(TASK_LIMIT)
  ) u_dec (
    .word  (cur_word[DW-1 -: SELW]),
    .code  (code),
    .addr  (addr),
    .tidx  (tidx),
    .legal (legal)
  );

  always_comb begin
    inc = '0;
    if (state == ST_NEXT && legal)
      inc[code[1:0]] = 1'b1;
  end

  bist_counters #(.NCNT(4), .CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (start),
    .inc (inc),
    .cnt (cnt)
  );

  assign cnt_s0 = cnt[0];
  assign cnt_s1 = cnt[1];
  assign cnt_s2 = cnt[2];
  assign cnt_tr = cnt[3];

  assign exp_val = (code == TGT_S2) ? DW'(cur_pat[DW-1 -: CS2W]) : cur_pat;
  assign any_err = err_pattern | err_index | err_addr;

  // memory ports decoded from registered state
  assign cs_addr  = addr;
  assign cs_we    = (state == ST_WR && code < TGT_TR) ? 3'(3'b001 << code[1:0]) : 3'b000;
  assign cs_wdata = exp_val;
  assign tr_addr  = (state == ST_INIT) ? init_idx : tidx;
  assign tr_we    = (state == ST_INIT) || (state == ST_REST) ||
                    (state == ST_WR && code == TGT_TR);
  always_comb begin
    case (state)
      ST_INIT: tr_wdata = DW'(init_idx);
      ST_REST: tr_wdata = DW'(tidx);
      default: tr_wdata = cur_pat;
    endcase
  end

  assign busy = (state != ST_IDLE) && (state != ST_DONE);
  assign done = (state == ST_DONE);
  assign pass = (state == ST_DONE) && !any_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      init_idx    <= '0;
      cur_word    <= '0;
      cur_pat     <= '0;
      have_word   <= 1'b0;
      iter        <= '0;
      rd_q        <= '0;
      err_pattern <= 1'b0;
      err_index   <= 1'b0;
      err_addr    <= 1'b0;
      fail_target <= '0;
      fail_addr   <= '0;
      fail_exp    <= '0;
      fail_act    <= '0;
    end else if (start) begin
      state       <= ST_INIT;
      init_idx    <= '0;
      have_word   <= 1'b0;
      iter        <= '0;
      err_pattern <= 1'b0;
      err_index   <= 1'b0;
      err_addr    <= 1'b0;
      fail_target <= '0;
      fail_addr   <= '0;
      fail_exp    <= '0;
      fail_act    <= '0;
    end else begin
      case (state)
        ST_INIT: begin
          init_idx <= init_idx + 1'b1;
          if (init_idx == TW'(NTASK - 1))
            state <= ST_FETCH;
        end
        ST_FETCH: begin
          if (!(loop_mode && have_word)) begin
            cur_word <= sel_word;
            cur_pat  <= pattern;
          end
          have_word <= 1'b1;
          state     <= ST_DECODE;
        end
        ST_DECODE: begin
          if (!legal) begin
            err_addr    <= 1'b1;
            fail_target <= code;
            fail_addr   <= (code == TGT_TR) ? AW'(tidx) : addr;
            state       <= ST_NEXT;
          end else if (code == TGT_TR) begin
            state <= ST_IRD;
          end else begin
            state <= ST_WR;
          end
        end
        ST_IRD: state <= ST_IWT;
        ST_IWT: begin
          rd_q  <= tr_rdata;
          state <= ST_ICMP;
        end
        ST_ICMP: begin
          if (rd_q != DW'(tidx)) begin
            err_index   <= 1'b1;
            fail_target <= TGT_TR;
            fail_addr   <= AW'(tidx);
            fail_exp    <= DW'(tidx);
            fail_act    <= rd_q;
          end
          state <= ST_WR;
        end
        ST_WR: state <= ST_RD;
        ST_RD: state <= ST_WT;
        ST_WT: begin
          case (code)
            TGT_S0:  rd_q <= cs_rdata0;
            TGT_S1:  rd_q <= cs_rdata1;
            TGT_S2:  rd_q <= DW'(cs_rdata2);
            default: rd_q <= tr_rdata;
          endcase
          state <= ST_CMP;
        end
        ST_CMP: begin
          if (rd_q != exp_val) begin
            err_pattern <= 1'b1;
            fail_target <= code;
            fail_addr   <= (code == TGT_TR) ? AW'(tidx) : addr;
            fail_exp    <= exp_val;
            fail_act    <= rd_q;
          end
          state <= (code == TGT_TR) ? ST_REST : ST_NEXT;
        end
        ST_REST: state <= ST_NEXT;
        ST_NEXT: begin
          iter <= iter + 1'b1;
          if ((any_err && !loop_mode) || iter == ITW'(ITERS - 1))
            state <= ST_DONE;
          else
            state <= ST_FETCH;
        end
        default: state <= state;
      endcase
    end
  end

endmodule

// File: rtl/bist_ctrl_chk.sv
module bist_ctrl_chk #(
  parameter int AW      = 12,
  parameter int LO_ADDR = 256,
  parameter int HI_ADDR = 3583,
  parameter int CNT_W   = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [AW-1:0]    cs_addr,
  input logic [2:0]       cs_we,
  input logic             tr_we,
  input logic             done,
  input logic             pass,
  input logic             err_pattern,
  input logic             err_index,
  input logic             err_addr,
  input logic [CNT_W-1:0] cnt_s0
);

  // R4
  cs_we_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (|cs_we) |-> (cs_addr >= AW'(LO_ADDR) && cs_addr <= AW'(HI_ADDR)));

  // R3
  one_slice_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_we));

  // R10
  quiet_when_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_we == 3'b000 && !tr_we));

  // R10
  pass_clean_chk: assert property (@(posedge clk) disable iff (rst)
    pass |-> (done && !err_pattern && !err_index && !err_addr));

  // R14
  sticky_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    (err_pattern && !start) |=> err_pattern);

  // R14
  sticky_index_chk: assert property (@(posedge clk) disable iff (rst)
    (err_index && !start) |=> err_index);

  // R14
  sticky_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (err_addr && !start) |=> err_addr);

  // R13
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> (cnt_s0 == $past(cnt_s0) || cnt_s0 == CNT_W'($past(cnt_s0) + 1'b1)));

endmodule

bind bist_ctrl bist_ctrl_chk #(
  .AW(AW), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sim_bist_ctrl.sv
module sim_bist_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        loop_mode = 1'b0;
  logic [15:0] sel_word = '0;
  logic [15:0] pattern = '0;
  logic [11:0] cs_addr;
  logic [2:0]  cs_we;
  logic [15:0] cs_wdata;
  logic [15:0] cs_rdata0, cs_rdata1;
  logic [3:0]  cs_rdata2;
  logic [3:0]  tr_addr;
  logic        tr_we;
  logic [15:0] tr_wdata;
  logic [15:0] tr_rdata;
  logic        busy, done, pass, err_pattern, err_index, err_addr;
  logic [2:0]  fail_target;
  logic [11:0] fail_addr;
  logic [15:0] fail_exp, fail_act;
  logic [15:0] cnt_s0, cnt_s1, cnt_s2, cnt_tr;

  int n_chk = 0;
  int n_err = 0;
  logic [1:0] fault = 2'd0;
  int wr_cnt = 0;
  int stray_wr = 0;
  logic [11:0] hold_addr = '0;
  logic [15:0] hold_pat = '0;
  logic        watch_hold = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bist_ctrl #(.ITERS(4)) u0 (
    .clk(clk), .rst(rst), .start(start), .loop_mode(loop_mode),
    .sel_word(sel_word), .pattern(pattern),
    .cs_addr(cs_addr), .cs_we(cs_we), .cs_wdata(cs_wdata),
    .cs_rdata0(cs_rdata0), .cs_rdata1(cs_rdata1), .cs_rdata2(cs_rdata2),
    .tr_addr(tr_addr), .tr_we(tr_we), .tr_wdata(tr_wdata), .tr_rdata(tr_rdata),
    .busy(busy), .done(done), .pass(pass),
    .err_pattern(err_pattern), .err_index(err_index), .err_addr(err_addr),
    .fail_target(fail_target), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_act(fail_act),
    .cnt_s0(cnt_s0), .cnt_s1(cnt_s1), .cnt_s2(cnt_s2), .cnt_tr(cnt_tr)
  );

  // memory models
  logic [15:0] m0 [4096];
  logic [15:0] m1 [4096];
  logic [3:0]  m2 [4096];
  logic [15:0] mt [16];
  logic [15:0] r0_q, r1_q, rt_q;
  logic [3:0]  r2_q;

  always @(posedge clk) begin
    r0_q <= m0[cs_addr];
    r1_q <= m1[cs_addr];
    r2_q <= m2[cs_addr];
    rt_q <= mt[tr_addr];
    if (cs_we[0]) m0[cs_addr] <= cs_wdata;
    if (cs_we[1]) m1[cs_addr] <= cs_wdata;
    if (cs_we[2]) m2[cs_addr] <= cs_wdata[3:0];
    if (tr_we)
      mt[tr_addr] <= (fault == 2'd2 && tr_wdata == {12'd0, tr_addr}) ?
                     (tr_wdata ^ 16'h0100) : tr_wdata;
    if (start) wr_cnt <= 0;
    else if (|cs_we) wr_cnt <= wr_cnt + 1;
    if (watch_hold && (|cs_we) && (cs_addr != hold_addr || cs_wdata != hold_pat))
      stray_wr <= stray_wr + 1;
  end

  assign cs_rdata0 = r0_q ^ ((fault == 2'd1) ? 16'h0001 : 16'h0000);
  assign cs_rdata1 = r1_q;
  assign cs_rdata2 = r2_q ^ ((fault == 2'd3) ? 4'h8 : 4'h0);
  assign tr_rdata  = rt_q;

  initial begin
    for (int i = 0; i < 4096; i++) begin
      m0[i] = '0; m1[i] = '0; m2[i] = '0;
    end
    for (int i = 0; i < 16; i++) mt[i] = '0;
  end

  typedef struct packed {
    logic [15:0] word;
    logic [15:0] pat;
    logic [1:0]  flt;
    logic [2:0]  flags;   // {pattern, index, addr}
    logic        pas;
    logic [7:0]  c0, c1, c2, ct;
    logic [3:0]  wr;
    logic [2:0]  ftgt;
    logic [11:0] faddr;
    logic        chkd;
    logic [15:0] fexp, fact;
  } vec_t;

  // 0-2: slice decode and range edges (R3 R4 R7 R13); 3-4: range misses (R4);
  // 5: reserved code (R5); 6: task pass (R8); 7: forbidden task (R6);
  // 8: data fault halts (R9 R10); 9: bad index (R8); 10: slice-2 fault (R7)
  localparam vec_t VEC [NVEC] = '{
    '{16'h0200, 16'hA5A5, 2'd0, 3'b000, 1'b1, 8'd4, 8'd0, 8'd0, 8'd0, 4'd4, 3'd0, 12'h000, 1'b0, 16'h0000, 16'h0000},
    '{16'h3BFE, 16'h1234, 2'd0, 3'b000, 1'b1, 8'd0, 8'd4, 8'd0, 8'd0, 4'd4, 3'd0, 12'h000, 1'b0, 16'h0000, 16'h0000},
    '{16'h4A00, 16'hC0FF, 2'd0, 3'b000, 1'b1, 8'd0, 8'd0, 8'd4, 8'd0, 4'd4, 3'd0, 12'h000, 1'b0, 16'h0000, 16'h0000},
    '{16'h01FE, 16'h5555, 2'd0, 3'b001, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 4'd0, 3'd0, 12'h0FF, 1'b0, 16'h0000, 16'h0000},
    '{16'h3C00, 16'h5555, 2'd0, 3'b001, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 4'd0, 3'd1, 12'hE00, 1'b0, 16'h0000, 16'h0000},
    '{16'hA000, 16'h5555, 2'd0, 3'b001, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 4'd0, 3'd5, 12'h000, 1'b0, 16'h0000, 16'h0000},
    '{16'h6600, 16'h0F0F, 2'd0, 3'b000, 1'b1, 8'd0, 8'd0, 8'd0, 8'd4, 4'd0, 3'd0, 12'h000, 1'b0, 16'h0000, 16'h0000},
    '{16'h7C00, 16'h0F0F, 2'd0, 3'b001, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 4'd0, 3'd3, 12'h00E, 1'b0, 16'h0000, 16'h0000},
    '{16'h0400, 16'h00FF, 2'd1, 3'b100, 1'b0, 8'd1, 8'd0, 8'd0, 8'd0, 4'd1, 3'd0, 12'h200, 1'b1, 16'h00FF, 16'h00FE},
    '{16'h6A00, 16'h3333, 2'd2, 3'b010, 1'b0, 8'd0, 8'd0, 8'd0, 8'd1, 4'd0, 3'd3, 12'h005, 1'b1, 16'h0005, 16'h0105},
    '{16'h4A00, 16'h7ABC, 2'd3, 3'b100, 1'b0, 8'd0, 8'd0, 8'd1, 8'd0, 4'd1, 3'd2, 12'h500, 1'b1, 16'h0007, 16'h000F}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] w, input logic [15:0] p,
                     input logic [1:0] f, input logic lm);
    @(negedge clk);
    sel_word  = w;
    pattern   = p;
    fault     = f;
    loop_mode = lm;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", {busy, done, pass, err_pattern, err_index, err_addr}, 6'b0);
    chk("R1 counters", {cnt_s0, cnt_s1, cnt_s2, cnt_tr}, 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      run(VEC[i].word, VEC[i].pat, VEC[i].flt, 1'b0);
      chk($sformatf("R4 R5 R6 R8 R9 flags v%0d", i),
          {err_pattern, err_index, err_addr}, VEC[i].flags);
      chk($sformatf("R10 pass v%0d", i), pass, VEC[i].pas);
      chk($sformatf("R13 counters v%0d", i), {cnt_s0, cnt_s1, cnt_s2, cnt_tr},
          {8'd0, VEC[i].c0, 8'd0, VEC[i].c1, 8'd0, VEC[i].c2, 8'd0, VEC[i].ct});
      chk($sformatf("R4 write count v%0d", i), 64'(wr_cnt), 64'(VEC[i].wr));
      if (VEC[i].flags != 3'b000)
        chk($sformatf("R9 fail location v%0d", i), {fail_target, fail_addr},
            {VEC[i].ftgt, VEC[i].faddr});
      if (VEC[i].chkd)
        chk($sformatf("R7 R9 fail data v%0d", i), {fail_exp, fail_act},
            {VEC[i].fexp, VEC[i].fact});
    end

    // R7: slice 2 stores the top pattern nibble
    run(16'h4A00, 16'hC0FF, 2'd0, 1'b0);
    chk("R7 slice2 content", m2[12'h500], 4'hC);

    // R2 and R8: every task register holds its index after a run
    run(16'h6600, 16'hBEEF, 2'd0, 1'b0);
    for (int i = 0; i < 16; i++)
      chk($sformatf("R2 R8 task reg %0d", i), mt[i], 16'(i));

    // R14: flags persist after a failed run, cleared by start
    run(16'h0400, 16'h00FF, 2'd1, 1'b0);
    repeat (10) @(negedge clk);
    chk("R14 sticky", {done, err_pattern}, 2'b11);
    @(negedge clk);
    fault = 2'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R14 cleared", {err_pattern, err_index, err_addr, busy}, 4'b0001);
    while (!done) @(negedge clk);

    // R11: loop mode runs through errors
    run(16'h0400, 16'h00FF, 2'd1, 1'b1);
    chk("R11 loop completes", {done, err_pattern, pass}, 3'b110);
    chk("R11 loop count", cnt_s0, 16'd4);

    // R12: loop mode keeps first word and pattern
    @(negedge clk);
    fault = 2'd0;
    loop_mode = 1'b1;
    sel_word = 16'h0600;
    pattern = 16'h1111;
    hold_addr = 12'h300;
    hold_pat = 16'h1111;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    watch_hold = 1'b1;
    while (cs_we == 3'b000) @(negedge clk);
    sel_word = 16'h2600;
    pattern = 16'h2222;
    while (!done) @(negedge clk);
    watch_hold = 1'b0;
    chk("R12 counters held", {cnt_s0, cnt_s1}, {16'd4, 16'd0});
    chk("R12 stray writes", 64'(stray_wr), 64'd0);
    chk("R12 memory", m0[12'h300], 16'h1111);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule